// File: doc/BRIEF.md
# Dual-Mode Interrupt Enable Controller

This block is the interrupt control register of a small CPU core, together with the gating that decides when a request goes to the core. The 8-bit register holds two gate bits at the top, three per-source enables and three per-source flags. The three flags belong to the core's own event sources: a timer overflow, an external interrupt pin and an input-port change detector. Each source delivers a one-cycle event pulse. A flag is set by its event whether or not anything is enabled, so software can poll the flags. Hardware never clears a flag.

A priority-mode input changes what the two gate bits mean. With priority mode off, bit 7 is a master enable and bit 6 gates only the peripheral requests. All requests leave on the high output, and the low output stays quiet. With priority mode on, bit 7 gates high-priority requests and bit 6 gates low-priority ones, and a low-priority request also needs bit 7. The three core sources always count as high priority. Peripheral requests arrive already masked by the peripheral's own enable, each with a tag that marks it high or low priority.

Top module: `dual_mode_irq_ctrl`

## Requirements
- R1: After a synchronous reset, register bits 7 through 1 read 0, and both request outputs are 0. The port-change flag (bit 0) has no defined reset value.
- R2: A write loads all eight bits, and the new value shows on the read port from the first clock edge after the write. Bit layout: 7 = global/high gate, 6 = peripheral/low gate, 5 = timer enable, 4 = external-pin enable, 3 = port-change enable, 2 = timer flag, 1 = external-pin flag, 0 = port-change flag.
- R3: An event pulse on src_evt_i sets the matching flag at the next clock edge, whatever the enables hold. src_evt_i bit 2 is the timer, bit 1 the external pin and bit 0 the port change.
- R4: A flag that is set stays set until software writes 0 to it. Writing 0 clears it.
- R5: If an event and a write of 0 reach the same flag in the same cycle, the flag ends up set.
- R6: With priority mode off, irq_hi_o = bit7 AND (some core flag with its enable set, OR bit6 AND any peripheral request).
- R7: With priority mode off, irq_lo_o is always 0.
- R8: With priority mode on, irq_hi_o = bit7 AND (some core flag with its enable set, OR any peripheral request tagged high, where per_hi_i = 1).
- R9: With priority mode on, irq_lo_o = bit7 AND bit6 AND any peripheral request tagged low (per_hi_i = 0).
- R10: While bit 7 is 0, both request outputs stay 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prio_mode_i | input | 1 | 1 = priority mode, 0 = legacy mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Current register contents |
| src_evt_i | input | 3 | Core event pulses: timer, external pin, port change |
| per_req_i | input | NUM_PERIPH | Masked peripheral requests |
| per_hi_i | input | NUM_PERIPH | Priority tag per peripheral (1 = high) |
| irq_hi_o | output | 1 | High-priority (or legacy) request to the core |
| irq_lo_o | output | 1 | Low-priority request to the core |

## Verification
Writes and event pulses each pass through exactly one register. The bench therefore drives them half a cycle before an edge and reads the register and the request outputs at the following falling edge. The request outputs are combinational from the register, the mode pin and the peripheral inputs. After a change to those inputs alone, the checks wait only a short settling delay and no clock edge. The stickiness checks hold the flags for several idle cycles before they read them.

// File: rtl/dmic_pkg.sv
// Shared definitions for the dual-mode interrupt controller.
// Assumes an 8-bit control register with a fixed bit layout that software decodes.
package dmic_pkg;

    localparam int REG_W   = 8;
    localparam int NUM_SRC = 3;   // timer, external pin, port change

    // Control register layout, bit 7 first.
    typedef struct packed {
        logic gate_hi;   // global enable / high-priority gate
        logic gate_lo;   // peripheral enable / low-priority gate
        logic en_tmr;
        logic en_ext;
        logic en_chg;
        logic fl_tmr;
        logic fl_ext;
        logic fl_chg;
    } ctrl_t;

    // Flags whose value reset defines: port-change flag (bit 0) is left open.
    localparam logic [NUM_SRC-1:0] FLAG_RST_MASK = 3'b110;

endpackage

// File: rtl/dmic_enable_reg.sv
// Holds the gate and per-source enable bits (register bits 7..3).
// Assumes one write strobe; all bits reset to 0 synchronously.
module dmic_enable_reg #(
    parameter int EN_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [EN_W-1:0] wr_bits,
    output logic [EN_W-1:0] en_q
);

    // Load on write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wr_bits;
        end
    end

endmodule

// File: rtl/dmic_flag_bank.sv
// Sticky event flags: set by a source pulse, cleared only by a software write of 0.
// Assumes single-cycle event pulses synchronous to clk. A set beats a clear in the
// same cycle. Flags outside RST_MASK keep their value through reset.
module dmic_flag_bank #(
    parameter int               N        = 3,
    parameter logic [N-1:0]     RST_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flag_q
);

    logic [N-1:0] flag_d;

    // Next value: software write (or hold), ORed with the hardware event.
    always_comb begin
        flag_d = (wr_en ? wr_bits : flag_q) | evt;
    end

    for (genvar i = 0; i < N; i++) begin : g_flag
        if (RST_MASK[i]) begin : g_rst
            // Flag with defined reset value 0.
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q[i] <= 1'b0;
                else        flag_q[i] <= flag_d[i];
            end
        end else begin : g_norst
            // Flag without reset: value after power-up is undefined.
            always_ff @(posedge clk) begin
                flag_q[i] <= flag_d[i];
            end
        end
    end

endmodule

// File: rtl/dmic_req_gate.sv
// Combinational request gating for legacy and priority modes.
// Assumes peripheral requests are already masked by their own enables.
module dmic_req_gate #(
    parameter int NUM_PERIPH = 4
) (
    input  logic                  prio_mode,
    input  dmic_pkg::ctrl_t       ctrl,
    input  logic [NUM_PERIPH-1:0] per_req,
    input  logic [NUM_PERIPH-1:0] per_hi,
    output logic                  irq_hi,
    output logic                  irq_lo
);

    logic core_pend;
    logic per_any;
    logic per_hi_any;
    logic per_lo_any;

    // Pending core sources: flag and its own enable both set.
    always_comb begin
        core_pend = (ctrl.fl_tmr & ctrl.en_tmr)
                  | (ctrl.fl_ext & ctrl.en_ext)
                  | (ctrl.fl_chg & ctrl.en_chg);
    end

    // Peripheral request summaries, split by priority tag.
    always_comb begin
        per_any    = |per_req;
        per_hi_any = |(per_req & per_hi);
        per_lo_any = |(per_req & ~per_hi);
    end

    // Output gating, chosen by the mode input.
    always_comb begin
        if (prio_mode) begin
            irq_hi = ctrl.gate_hi & (core_pend | per_hi_any);
            irq_lo = ctrl.gate_hi & ctrl.gate_lo & per_lo_any;
        end else begin
            irq_hi = ctrl.gate_hi & (core_pend | (ctrl.gate_lo & per_any));
            irq_lo = 1'b0;
        end
    end

endmodule

// File: rtl/dual_mode_irq_ctrl.sv
// Top level: the 8-bit interrupt control register and its request gating.
// Assumes a synchronous active-low reset and one-cycle event pulses.
module dual_mode_irq_ctrl #(
    parameter int NUM_PERIPH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prio_mode_i,
    input  logic                  wr_en_i,
    input  logic [7:0]            wr_data_i,
    output logic [7:0]            rd_data_o,
    input  logic [2:0]            src_evt_i,
    input  logic [NUM_PERIPH-1:0] per_req_i,
    input  logic [NUM_PERIPH-1:0] per_hi_i,
    output logic                  irq_hi_o,
    output logic                  irq_lo_o
);

    import dmic_pkg::*;

    localparam int EN_W = REG_W - NUM_SRC;

    logic [EN_W-1:0]    en_q;
    logic [NUM_SRC-1:0] flag_q;
    ctrl_t              ctrl;

    dmic_enable_reg #(.EN_W(EN_W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_bits (wr_data_i[REG_W-1:NUM_SRC]),
        .en_q    (en_q)
    );

    dmic_flag_bank #(.N(NUM_SRC), .RST_MASK(FLAG_RST_MASK)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_bits (wr_data_i[NUM_SRC-1:0]),
        .evt     (src_evt_i),
        .flag_q  (flag_q)
    );

    // Assemble the visible register from the two storage blocks.
    always_comb begin
        ctrl = ctrl_t'({en_q, flag_q});
    end

    assign rd_data_o = ctrl;

    dmic_req_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
        .prio_mode (prio_mode_i),
        .ctrl      (ctrl),
        .per_req   (per_req_i),
        .per_hi    (per_hi_i),
        .irq_hi    (irq_hi_o),
        .irq_lo    (irq_lo_o)
    );

endmodule

// File: rtl/dmic_checker.sv
// Property checker for dual_mode_irq_ctrl, observing ports only.
module dmic_checker #(
    parameter int NUM_PERIPH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  prio_mode_i,
    input logic                  wr_en_i,
    input logic [7:0]            wr_data_i,
    input logic [7:0]            rd_data_o,
    input logic [2:0]            src_evt_i,
    input logic [NUM_PERIPH-1:0] per_req_i,
    input logic                  irq_hi_o,
    input logic                  irq_lo_o
);

    // Reset clears bits 7..1.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data_o[7:1] == 7'd0));

    // A write with no event lands unchanged.
    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (src_evt_i == 3'b000)) |=> (rd_data_o == $past(wr_data_i)));

    for (genvar i = 0; i < 3; i++) begin : g_flag_chk
        // Event sets its flag at the next edge.
        assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt_i[i] |=> rd_data_o[i]);
        // Flags are not cleared without a write.
        assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data_o[i] && !wr_en_i) |=> rd_data_o[i]);
        // Event beats a clearing write.
        assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !wr_data_i[i] && src_evt_i[i]) |=> rd_data_o[i]);
    end

    // Low output quiet in legacy mode.
    assert_legacy_lo_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_mode_i |-> !irq_lo_o);

    // Low request needs both gate bits.
    assert_lo_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo_o |-> (rd_data_o[7] && rd_data_o[6]));

    // Bit 7 clear blocks every request.
    assert_gate_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[7] |-> (!irq_hi_o && !irq_lo_o));

endmodule

bind dual_mode_irq_ctrl dmic_checker #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prio_mode_i (prio_mode_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .src_evt_i   (src_evt_i),
    .per_req_i   (per_req_i),
    .irq_hi_o    (irq_hi_o),
    .irq_lo_o    (irq_lo_o)
);

// File: tb/dual_mode_irq_ctrl_test.sv
`timescale 1ns/1ps
module dual_mode_irq_ctrl_test;

    localparam int NP = 4;
    localparam int NV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prio_mode_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [7:0]    wr_data_i = 8'h00;
    logic [7:0]    rd_data_o;
    logic [2:0]    src_evt_i = 3'b000;
    logic [NP-1:0] per_req_i = '0;
    logic [NP-1:0] per_hi_i = '0;
    logic          irq_hi_o;
    logic          irq_lo_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dual_mode_irq_ctrl #(.NUM_PERIPH(NP)) uut (
        .clk(clk), .rst_n(rst_n), .prio_mode_i(prio_mode_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .src_evt_i(src_evt_i), .per_req_i(per_req_i), .per_hi_i(per_hi_i),
        .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o)
    );

    // {mode, ctrl[7:0], req[3:0], hi_tag[3:0], exp_hi, exp_lo}
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 8'h24, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R10 gate closed
        {1'b0, 8'hA4, 4'b0000, 4'b0000, 1'b1, 1'b0}, // R6 timer
        {1'b0, 8'hA2, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R6 flag w/o enable
        {1'b0, 8'h92, 4'b0000, 4'b0000, 1'b1, 1'b0}, // R6 ext pin
        {1'b0, 8'h89, 4'b0000, 4'b0000, 1'b1, 1'b0}, // R6 port change
        {1'b0, 8'h80, 4'b0100, 4'b0000, 1'b0, 1'b0}, // R6 peripheral gate off
        {1'b0, 8'hC0, 4'b0100, 4'b0000, 1'b1, 1'b0}, // R6 R7 peripheral
        {1'b0, 8'h40, 4'b1111, 4'b1111, 1'b0, 1'b0}, // R10
        {1'b1, 8'hC0, 4'b0001, 4'b0001, 1'b1, 1'b0}, // R8 high peripheral
        {1'b1, 8'hC0, 4'b0010, 4'b0001, 1'b0, 1'b1}, // R9 low peripheral
        {1'b1, 8'h80, 4'b0010, 4'b0000, 1'b0, 1'b0}, // R9 low gate off
        {1'b1, 8'h40, 4'b0011, 4'b0001, 1'b0, 1'b0}, // R10 priority mode
        {1'b1, 8'hA4, 4'b0000, 4'b0000, 1'b1, 1'b0}, // R8 core as high
        {1'b1, 8'hC4, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R8 flag w/o enable
        {1'b1, 8'hE4, 4'b1000, 4'b0000, 1'b1, 1'b1}  // R8 R9 both
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_reg(input logic [7:0] v, input logic [2:0] evt);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = v;
        src_evt_i = evt;
        @(negedge clk);
        wr_en_i   = 1'b0;
        src_evt_i = 3'b000;
    endtask

    task automatic pulse_evt(input logic [2:0] evt);
        @(negedge clk);
        src_evt_i = evt;
        @(negedge clk);
        src_evt_i = 3'b000;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 bits7..1", {1'b0, rd_data_o[7:1]}, 8'h00);
        check("R1 irq", {6'd0, irq_hi_o, irq_lo_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {1'b0, rd_data_o[7:1]}, 8'h00);

        // Table walk: R2, R6, R7, R8, R9, R10
        for (int k = 0; k < NV; k++) begin
            write_reg(VEC[k][17:10], 3'b000);
            prio_mode_i = VEC[k][18];
            per_req_i   = VEC[k][9:6];
            per_hi_i    = VEC[k][5:2];
            #1;
            check("R2 readback", rd_data_o, VEC[k][17:10]);
            check(VEC[k][18] ? "R8 irq_hi" : "R6 irq_hi", {7'd0, irq_hi_o}, {7'd0, VEC[k][1]});
            check(VEC[k][18] ? "R9 irq_lo" : "R7 irq_lo", {7'd0, irq_lo_o}, {7'd0, VEC[k][0]});
        end

        // R10: bit 7 clear with everything else set, priority mode
        per_req_i = '1; per_hi_i = 4'b0101; prio_mode_i = 1'b1;
        write_reg(8'h7F, 3'b000);
        #1;
        check("R10 both blocked", {6'd0, irq_hi_o, irq_lo_o}, 8'h00);
        per_req_i = '0;

        // R3: event sets flag with all enables off
        write_reg(8'h00, 3'b000);
        pulse_evt(3'b100);
        check("R3 timer flag", rd_data_o, 8'h04);
        check("R3 no request", {7'd0, irq_hi_o}, 8'h00);
        pulse_evt(3'b001);
        check("R3 port flag", rd_data_o, 8'h05);

        // R4: flags hold through idle cycles, then clear on write of 0
        repeat (5) @(negedge clk);
        check("R4 sticky", rd_data_o, 8'h05);
        write_reg(8'h00, 3'b000);
        check("R4 cleared", rd_data_o, 8'h00);

        // R5: event and clearing write in the same cycle
        write_reg(8'h00, 3'b010);
        check("R5 set wins", rd_data_o, 8'h02);

        // R6: event raises request one edge later in legacy mode
        prio_mode_i = 1'b0;
        write_reg(8'h90, 3'b000);
        check("R6 pre event", {7'd0, irq_hi_o}, 8'h00);
        pulse_evt(3'b010);
        check("R6 post event", {7'd0, irq_hi_o}, 8'h01);

        done = 1'b1;
        finish_run();
    end

endmodule